// File: doc/BRIEF.md
# TDM Multichannel Slot Selector

This block follows the time slots of a serial frame for a multichannel serial port and decides, slot by slot, whether a word is moved. A frame-sync pulse starts a frame at channel 0. Each word-complete strobe from the shifter moves the selector to the next channel. A channel-enable map of 128 bits, with one bit for each channel, together with a partition mode, decides which slots carry data. One instance serves one direction, receive or transmit.

Channels are grouped in 16-channel blocks. In eight-partition mode, block n always belongs to partition n (A through H), and every block is eligible. In two-partition mode, only two blocks are eligible. One even-numbered block is named for partition A and one odd-numbered block is named for partition B. Channels in all other blocks stay disabled, whatever the map holds. The frame length is programmed as the number of slots minus one. When the last slot's word completes, the selector parks until the next frame sync.

Top module: `tdm_slot_select`

## Requirements
- R1: During reset and after it, until the first frame sync, `chan_idx` is 0, `part_idx` is 0 and `slot_en` is 0. Word strobes in that interval change nothing.
- R2: A frame sync sampled at a clock edge makes `chan_idx` 0 after that edge. `slot_en` then shows channel 0's eligibility.
- R3: While a frame is running, each word strobe sampled at an edge below the last slot raises `chan_idx` by one after that edge. Without a strobe, `chan_idx` holds.
- R4: With `frame_len_m1` = L, a frame has L+1 slots, channels 0 to L. A strobe at channel L or above ends the frame. `slot_en` then drops, `chan_idx` holds, and further strobes are ignored until the next frame sync.
- R5: `slot_en` is 1 only in a running frame where `chan_map[chan_idx]` is 1 (bit i is channel i) and the channel's block is eligible. For example, with L = 39 and bits 0, 15 and 39 set in eight-partition mode, exactly three slots of the frame are enabled.
- R6: `part_idx` always equals `chan_idx` shifted right by four, where 0 is A and 7 is H.
- R7: With `eight_part_en` = 1, all eight blocks are eligible, and `blk_sel_a` and `blk_sel_b` have no effect.
- R8: With `eight_part_en` = 0, the only eligible blocks are 2·`blk_sel_a` and 2·`blk_sel_b`+1. Channels in any other block give `slot_en` = 0.
- R9: A frame sync in the middle of a frame, or together with a word strobe, restarts at channel 0 at that same edge. The sync takes priority over the strobe.
- R10: A frame sync after a frame has ended starts a new frame at channel 0, partition A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_sync | input | 1 | Frame start pulse |
| word_done | input | 1 | Word-complete strobe from the shifter |
| frame_len_m1 | input | 7 | Slots per frame minus one |
| eight_part_en | input | 1 | 1 selects eight-partition mode |
| blk_sel_a | input | 2 | Two-partition mode: even block 2·value for partition A |
| blk_sel_b | input | 2 | Two-partition mode: odd block 2·value+1 for partition B |
| chan_map | input | 128 | Enable bit for each channel |
| chan_idx | output | 7 | Current channel (slot) number |
| part_idx | output | 3 | Current partition index (0 = A) |
| slot_en | output | 1 | Word in this slot is transferred |

## Verification
The hardest states to reach are the parked state after the final slot, and a frame sync that lands on the same edge as a strobe. Both depend on how the strobes line up against the programmed length. Directed sequences run a frame past its last slot and keep strobing while parked, and they place a sync on the strobe edge and mid-frame. The random phase uses short frame lengths and sparse syncs, so frames often end and park before the next sync arrives. It also redraws the mode, the block selects and the map between frames.

// File: rtl/tdm_sel_pkg.sv
package tdm_sel_pkg;
  localparam int unsigned DEF_NUM_CH = 128;
  localparam int unsigned DEF_BLK_SZ = 16;
endpackage

// File: rtl/tdm_slot_counter.sv
module tdm_slot_counter #(
  parameter int unsigned CH_W = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            frame_sync,
  input  logic            word_done,
  input  logic [CH_W-1:0] frame_last,
  output logic [CH_W-1:0] cnt_nxt,
  output logic            act_nxt,
  output logic [CH_W-1:0] cnt_q,
  output logic            act_q
);
  always_comb begin
    cnt_nxt = cnt_q;
    act_nxt = act_q;
    if (frame_sync) begin
      cnt_nxt = '0;
      act_nxt = 1'b1;
    end else if (word_done && act_q) begin
      if (cnt_q >= frame_last) act_nxt = 1'b0;
      else                     cnt_nxt = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      act_q <= act_nxt;
    end
  end

  // R9
  sync_restart_chk: assert property (@(posedge clk) disable iff (rst)
    frame_sync |=> (cnt_q == '0 && act_q));
  // R3
  advance_chk: assert property (@(posedge clk) disable iff (rst)
    (!frame_sync && word_done && act_q && cnt_q < frame_last)
      |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R4
  frame_close_chk: assert property (@(posedge clk) disable iff (rst)
    (!frame_sync && word_done && act_q && cnt_q >= frame_last) |=> !act_q);
  // R4
  park_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!frame_sync && !act_q) |=> (!act_q && $stable(cnt_q)));
endmodule

// File: rtl/tdm_chan_gate.sv
module tdm_chan_gate #(
  parameter int unsigned NUM_CH = 128,
  parameter int unsigned BLK_SZ = 16,
  localparam int unsigned CH_W  = $clog2(NUM_CH),
  localparam int unsigned NUM_BLK = NUM_CH / BLK_SZ,
  localparam int unsigned BLK_W = $clog2(NUM_BLK),
  localparam int unsigned SEL_W = $clog2(NUM_BLK / 2)
) (
  input  logic              eight_part_en,
  input  logic [SEL_W-1:0]  blk_sel_a,
  input  logic [SEL_W-1:0]  blk_sel_b,
  input  logic [NUM_CH-1:0] chan_map,
  input  logic [CH_W-1:0]   chan,
  output logic              chan_ok
);
  logic [NUM_BLK-1:0] blk_ok;
  logic [BLK_W-1:0]   blk;

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    localparam int unsigned HALF = b / 2;
    if ((b % 2) == 0) begin : g_even
      assign blk_ok[b] = eight_part_en || (blk_sel_a == SEL_W'(HALF));
    end else begin : g_odd
      assign blk_ok[b] = eight_part_en || (blk_sel_b == SEL_W'(HALF));
    end
  end

  assign blk     = chan[CH_W-1 -: BLK_W];
  assign chan_ok = chan_map[chan] && blk_ok[blk];
endmodule

// File: rtl/tdm_slot_select.sv
module tdm_slot_select #(
  parameter int unsigned NUM_CH = tdm_sel_pkg::DEF_NUM_CH,
  parameter int unsigned BLK_SZ = tdm_sel_pkg::DEF_BLK_SZ,
  localparam int unsigned CH_W  = $clog2(NUM_CH),
  localparam int unsigned NUM_BLK = NUM_CH / BLK_SZ,
  localparam int unsigned BLK_W = $clog2(NUM_BLK),
  localparam int unsigned SEL_W = $clog2(NUM_BLK / 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_sync,
  input  logic              word_done,
  input  logic [CH_W-1:0]   frame_len_m1,
  input  logic              eight_part_en,
  input  logic [SEL_W-1:0]  blk_sel_a,
  input  logic [SEL_W-1:0]  blk_sel_b,
  input  logic [NUM_CH-1:0] chan_map,
  output logic [CH_W-1:0]   chan_idx,
  output logic [BLK_W-1:0]  part_idx,
  output logic              slot_en
);
  logic [CH_W-1:0]  cnt_nxt, cnt_q;
  logic             act_nxt, act_q;
  logic             nxt_ok;
  logic [BLK_W-1:0] part_q;
  logic             en_q;

  tdm_slot_counter #(.CH_W(CH_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .frame_sync (frame_sync),
    .word_done  (word_done),
    .frame_last (frame_len_m1),
    .cnt_nxt    (cnt_nxt),
    .act_nxt    (act_nxt),
    .cnt_q      (cnt_q),
    .act_q      (act_q)
  );

  tdm_chan_gate #(.NUM_CH(NUM_CH), .BLK_SZ(BLK_SZ)) u_gate (
    .eight_part_en (eight_part_en),
    .blk_sel_a     (blk_sel_a),
    .blk_sel_b     (blk_sel_b),
    .chan_map      (chan_map),
    .chan          (cnt_nxt),
    .chan_ok       (nxt_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      part_q <= '0;
      en_q   <= 1'b0;
    end else begin
      part_q <= cnt_nxt[CH_W-1 -: BLK_W];
      en_q   <= act_nxt && nxt_ok;
    end
  end

  assign chan_idx = cnt_q;
  assign part_idx = part_q;
  assign slot_en  = en_q;

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (chan_idx == '0 && part_idx == '0 && !slot_en));
  // R5
  en_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    slot_en |-> act_q);
  // R6
  part_track_chk: assert property (@(posedge clk) disable iff (rst)
    part_idx == chan_idx[CH_W-1 -: BLK_W]);
endmodule

// File: tb/tb_tdm_slot_select.sv
`timescale 1ns/1ps
module tb_tdm_slot_select;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         frame_sync = 1'b0;
  logic         word_done = 1'b0;
  logic [6:0]   frame_len_m1 = 7'd0;
  logic         eight_part_en = 1'b1;
  logic [1:0]   blk_sel_a = 2'd0;
  logic [1:0]   blk_sel_b = 2'd0;
  logic [127:0] chan_map = '0;
  logic [6:0]   chan_idx;
  logic [2:0]   part_idx;
  logic         slot_en;

  int total = 0;
  int bad = 0;
  logic [6:0] m_cnt = 7'd0;
  bit         m_act = 1'b0;

  always #2.5 clk = ~clk;

  tdm_slot_select dut (
    .clk(clk), .rst(rst), .frame_sync(frame_sync), .word_done(word_done),
    .frame_len_m1(frame_len_m1), .eight_part_en(eight_part_en),
    .blk_sel_a(blk_sel_a), .blk_sel_b(blk_sel_b), .chan_map(chan_map),
    .chan_idx(chan_idx), .part_idx(part_idx), .slot_en(slot_en)
  );

  function automatic bit exp_en(input logic [6:0] c, input bit act);
    int blk;
    bit ok;
    blk = int'(c) / 16;
    ok = eight_part_en || (blk == 2 * int'(blk_sel_a)) || (blk == 2 * int'(blk_sel_b) + 1);
    return act && chan_map[c] && ok;
  endfunction

  task automatic check(input string tag);
    bit e;
    e = exp_en(m_cnt, m_act);
    total++;
    if (chan_idx !== m_cnt || part_idx !== m_cnt[6:4] || slot_en !== e) begin
      bad++;
      $display("FAIL %s: chan=%0d part=%0d en=%0b expected chan=%0d part=%0d en=%0b",
               tag, chan_idx, part_idx, slot_en, m_cnt, m_cnt[6:4], e);
    end
  endtask

  task automatic cyc(input bit s, input bit w, input string tag);
    frame_sync = s;
    word_done  = w;
    if (s) begin
      m_cnt = 7'd0; m_act = 1'b1;
    end else if (w && m_act) begin
      if (m_cnt >= frame_len_m1) m_act = 1'b0;
      else m_cnt = m_cnt + 7'd1;
    end
    @(posedge clk); #1;
    check(tag);
  endtask

  task automatic tally(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n_en;
    void'($urandom(32'd7741));
    repeat (3) @(posedge clk);
    #1; check("R1 in reset");
    rst = 1'b0;
    chan_map = '1;
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1, "R1 strobe before sync");

    // R5: channels 0, 15, 39 with 40 slots
    chan_map = '0; chan_map[0] = 1'b1; chan_map[15] = 1'b1; chan_map[39] = 1'b1;
    frame_len_m1 = 7'd39; eight_part_en = 1'b1;
    cyc(1'b1, 1'b0, "R2 sync");
    n_en = slot_en ? 1 : 0;
    for (int i = 0; i < 45; i++) begin
      cyc(1'b0, 1'b1, "R3 R4 walk");
      if (slot_en) n_en++;
    end
    tally("R5 enabled slot count", n_en, 3);
    tally("R4 parked channel", int'(chan_idx), 39);
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, "R4 park idle");
    cyc(1'b1, 1'b0, "R10 restart after end");
    tally("R10 partition A", int'(part_idx), 0);

    // R9: mid-frame sync and sync with strobe
    chan_map = '1; frame_len_m1 = 7'd127;
    for (int i = 0; i < 20; i++) cyc(1'b0, 1'b1, "R3 advance");
    cyc(1'b1, 1'b0, "R9 mid-frame sync");
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, "R3 advance");
    cyc(1'b1, 1'b1, "R9 sync with strobe");
    tally("R9 channel after sync+strobe", int'(chan_idx), 0);

    // R8: two-partition mode, blocks 2 and 1
    eight_part_en = 1'b0; blk_sel_a = 2'd1; blk_sel_b = 2'd0;
    cyc(1'b1, 1'b0, "R8 sync");
    n_en = 0;
    for (int i = 0; i < 127; i++) begin
      cyc(1'b0, 1'b1, "R8 two-partition walk");
      if (slot_en) n_en++;
    end
    tally("R8 enabled slots (blocks 1,2)", n_en, 32);

    // R7: eight-partition ignores selects; R6 partition H
    eight_part_en = 1'b1; blk_sel_a = 2'd3; blk_sel_b = 2'd3;
    cyc(1'b1, 1'b0, "R7 sync");
    n_en = slot_en ? 1 : 0;
    for (int i = 0; i < 127; i++) begin
      cyc(1'b0, 1'b1, "R7 eight-partition walk");
      if (slot_en) n_en++;
    end
    tally("R7 all slots enabled", n_en, 128);
    tally("R6 last partition H", int'(part_idx), 7);

    // random phase
    for (int i = 0; i < 6000; i++) begin
      if (i % 300 == 0) begin
        eight_part_en = 1'($urandom);
        blk_sel_a = 2'($urandom);
        blk_sel_b = 2'($urandom);
        frame_len_m1 = (i % 600 == 0) ? 7'($urandom % 24) : 7'($urandom);
        chan_map = {$urandom, $urandom, $urandom, $urandom};
      end
      cyc(($urandom % 50) == 0, ($urandom % 3) == 0, "R5 R6 R9 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule